// File: doc/BRIEF.md
# Boolean Reachability Closure Array

This block takes the adjacency matrix of a small directed graph and returns its reachability matrix. Bit `i*N+j` of the input is set when an edge runs from node `i` to node `j`. The same bit of the output is set when node `j` can be reached from node `i` by any number of edges, zero included. The matrix is held in a square grid of one-bit cells. Each cell keeps one entry of the matrix and updates it with an AND/OR rule. This rule takes the place of the multiply/add step of an ordinary matrix product.

A one-cycle `start_i` pulse loads the whole matrix in parallel. A controller then walks a pivot index through every node, one node per clock. In each pivot phase, the pivot's row and column of the current matrix are fanned out to every cell. After the last pivot, `done_o` rises and the result stays on `closure_o` until the next start. The whole computation takes N+1 clock edges from the start pulse, with no repeated squaring.

Top module: `tc_closure_array`

## Requirements
- R1: On a clock edge where `start_i` is high, the matrix register is loaded with `adj_i` ORed with the identity (bit `d*N+d` set for every node d). `busy_o` is 1 and `done_o` is 0 after that edge.
- R2: In the phase for pivot k, entry (i,j) becomes 1 if it was already 1, or if entries (i,k) and (k,j) were both 1 in the matrix as it stood before that phase. The entries feeding the rule are taken from the pre-phase state, not from values updated within the same phase.
- R3: Pivot phases run on the N edges after the load edge, for k = 0 to N-1, one phase per clock. `done_o` is 1 and `busy_o` is 0 after the (N+1)-th edge counted from the start edge. `busy_o` and `done_o` are never both 1.
- R4: When `done_o` is 1, bit `i*N+j` of `closure_o` is 1 exactly when a directed path of length zero or more leads from node i to node j in the loaded graph.
- R5: While phases run, no entry of the matrix goes from 1 to 0.
- R6: While neither busy nor starting, `closure_o` and `done_o` hold their values, whatever `adj_i` does.
- R7: A start pulse while `busy_o` is 1 abandons the run in progress. It reloads the matrix from the new `adj_i` and begins again at pivot 0.
- R8: Synchronous reset clears the matrix, `busy_o` and `done_o`.
- R9: Whenever `busy_o` or `done_o` is 1, every diagonal bit of `closure_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load `adj_i` and begin a closure run |
| adj_i | input | N*N | Adjacency matrix, bit i*N+j = edge i to j |
| closure_o | output | N*N | Current matrix; reachability result when done |
| busy_o | output | 1 | Pivot phases in progress |
| done_o | output | 1 | Result valid, held until next start |

## Verification
The embedded properties assume that `rst` and `start_i` are synchronous to `clk` and never unknown. They also assume that `adj_i` only matters on an edge where `start_i` is high. Apart from that, the stability check takes no view of how `adj_i` moves while idle. The stimulus drives every input on the falling edge and pulses start for one cycle, except in the restart case, which deliberately lands a second pulse mid-run. Between runs, the bench changes `adj_i` on purpose while start stays low. This shows that the held result is not disturbed.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tc_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } tc_cmd_t;

    function automatic int unsigned flat_idx(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned n);
        return row * n + col;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import tc_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned KW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output tc_cmd_t       cmd_o,
    output logic [KW-1:0] pivot_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [KW-1:0] LAST = KW'(N - 1);

    tc_state_e     st_q;
    logic [KW-1:0] k_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            k_q  <= '0;
        end else if (start_i) begin
            st_q <= ST_RUN;
            k_q  <= '0;
        end else if (st_q == ST_RUN) begin
            if (k_q == LAST) begin
                st_q <= ST_DONE;
                k_q  <= '0;
            end else begin
                k_q <= k_q + 1'b1;
            end
        end
    end

    always_comb begin
        cmd_o.load = start_i;
        cmd_o.step = (st_q == ST_RUN) && !start_i;
    end

    assign pivot_o = k_q;
    assign busy_o  = (st_q == ST_RUN);
    assign done_o  = (st_q == ST_DONE);

    p_last_phase_done_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start_i && k_q == LAST) |=> (done_o && !busy_o));
    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));
    p_pivot_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (k_q <= LAST));
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (busy_o && k_q == '0));
endmodule

// File: rtl/tc_pivot.sv
module tc_pivot
    import tc_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned KW = idx_width(N),
    parameter int unsigned NN = N * N
) (
    input  logic [NN-1:0] mat_i,
    input  logic [KW-1:0] pivot_i,
    output logic [N-1:0]  prow_o,
    output logic [N-1:0]  pcol_o
);
    always_comb begin
        for (int unsigned x = 0; x < N; x++) begin
            prow_o[x] = mat_i[flat_idx(32'(pivot_i), x, N)];
            pcol_o[x] = mat_i[flat_idx(x, 32'(pivot_i), N)];
        end
    end
endmodule

// File: rtl/tc_cell.sv
module tc_cell
    import tc_pkg::*;
#(
    parameter bit ON_DIAG = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  tc_cmd_t cmd_i,
    input  logic    adj_bit_i,
    input  logic    via_in_i,
    input  logic    via_out_i,
    output logic    q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (cmd_i.load)
            q_o <= adj_bit_i | ON_DIAG;
        else if (cmd_i.step)
            q_o <= q_o | (via_in_i & via_out_i);
    end

    p_monotone_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step && q_o) |=> q_o);
    p_join_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step && via_in_i && via_out_i) |=> q_o);
    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_i.load |=> (q_o == ($past(adj_bit_i) | ON_DIAG)));
endmodule

// File: rtl/tc_closure_array.sv
module tc_closure_array
    import tc_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N*N-1:0] adj_i,
    output logic [N*N-1:0] closure_o,
    output logic           busy_o,
    output logic           done_o
);
    localparam int unsigned KW = idx_width(N);
    localparam int unsigned NN = N * N;

    tc_cmd_t       cmd;
    logic [KW-1:0] pivot;
    logic [N-1:0]  prow;
    logic [N-1:0]  pcol;
    logic [NN-1:0] mat;
    logic [N-1:0]  diag;

    tc_ctrl #(.N(N), .KW(KW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .cmd_o  (cmd),
        .pivot_o(pivot),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    tc_pivot #(.N(N), .KW(KW), .NN(NN)) u_pivot (
        .mat_i  (mat),
        .pivot_i(pivot),
        .prow_o (prow),
        .pcol_o (pcol)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            tc_cell #(.ON_DIAG(gi == gj)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .cmd_i    (cmd),
                .adj_bit_i(adj_i[gi*N+gj]),
                .via_in_i (pcol[gi]),
                .via_out_i(prow[gj]),
                .q_o      (mat[gi*N+gj])
            );
        end
        assign diag[gi] = mat[gi*N+gi];
    end

    assign closure_o = mat;

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(closure_o) && $stable(done_o)));
    p_diag_set_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o || done_o) |-> (&diag));
endmodule

// File: tb/sim_tc_closure_array.sv
`timescale 1ns/1ps
module sim_tc_closure_array;
    localparam int N  = 8;
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [NN-1:0] adj;
    logic [NN-1:0] clo;
    logic          busy;
    logic          done;

    always #2.5 clk = ~clk;

    tc_closure_array #(.N(N)) u0 (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .adj_i    (adj),
        .closure_o(clo),
        .busy_o   (busy),
        .done_o   (done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_en  = 1'b0;
    bit ended   = 1'b0;

    // behavioural cycle model
    logic [NN-1:0] m_mat  = '0;
    bit            m_busy = 1'b0;
    bit            m_done = 1'b0;
    bit            m_load = 1'b0;
    int            m_k    = 0;

    always @(posedge clk) begin
        logic [NN-1:0] snap;
        m_load = 1'b0;
        if (rst) begin
            m_mat = '0; m_busy = 0; m_done = 0; m_k = 0;
        end else if (start) begin
            m_mat = adj;
            for (int d = 0; d < N; d++) m_mat[d*N+d] = 1'b1;
            m_busy = 1; m_done = 0; m_k = 0; m_load = 1'b1;
        end else if (m_busy) begin
            snap = m_mat;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (snap[i*N+m_k] && snap[m_k*N+j]) m_mat[i*N+j] = 1'b1;
            if (m_k == N - 1) begin
                m_busy = 0; m_done = 1;
            end else begin
                m_k++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NN-1:0] act, input logic [NN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [NN-1:0] prev_clo = '0;
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(clo == m_mat, "R2", "matrix vs model", clo, m_mat);
            chk(busy == m_busy, "R3", "busy vs model", NN'(busy), NN'(m_busy));
            chk(done == m_done, "R3", "done vs model", NN'(done), NN'(m_done));
            if (busy && !m_load)
                chk((prev_clo & ~clo) == '0, "R5", "bit cleared", clo, prev_clo | clo);
            if (busy || done)
                for (int d = 0; d < N; d++)
                    if (!clo[d*N+d]) chk(1'b0, "R9", "diagonal", clo, clo | (NN'(1) << (d*N+d)));
        end
        prev_clo = clo;
    end

    function automatic logic [NN-1:0] reach(input logic [NN-1:0] a);
        logic [NN-1:0] r = '0;
        for (int s = 0; s < N; s++) begin
            int q[$];
            bit seen[N];
            for (int v = 0; v < N; v++) seen[v] = 1'b0;
            q.push_back(s);
            seen[s] = 1'b1;
            while (q.size() > 0) begin
                int u;
                u = q.pop_front();
                r[s*N+u] = 1'b1;
                for (int v = 0; v < N; v++)
                    if (a[u*N+v] && !seen[v]) begin
                        seen[v] = 1'b1;
                        q.push_back(v);
                    end
            end
        end
        return r;
    endfunction

    function automatic logic [NN-1:0] with_diag(input logic [NN-1:0] a);
        logic [NN-1:0] r = a;
        for (int d = 0; d < N; d++) r[d*N+d] = 1'b1;
        return r;
    endfunction

    function automatic logic [NN-1:0] rnd_graph(input int dens);
        logic [NN-1:0] g = '0;
        for (int b = 0; b < NN; b++) g[b] = (($urandom % 100) < dens);
        return g;
    endfunction

    task automatic run_graph(input logic [NN-1:0] g, input string tag);
        int lat;
        @(negedge clk); adj = g; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(clo == with_diag(g) && busy && !done, "R1", {tag, " load"}, clo, with_diag(g));
        lat = 1;
        while (!done && lat < 4 * N) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == N + 1, "R3", {tag, " latency"}, NN'(lat), NN'(N + 1));
        chk(clo == reach(g), "R4", {tag, " closure"}, clo, reach(g));
    endtask

    initial begin
        logic [NN-1:0] g;
        logic [NN-1:0] held;
        rst = 1'b1; start = 1'b0; adj = '1;
        repeat (3) @(negedge clk);
        chk(clo == '0 && !busy && !done, "R8", "reset state", clo, '0);
        rst = 1'b0;
        cmp_en = 1'b1;

        run_graph('0, "empty");
        run_graph('1, "full");
        g = '0;
        for (int i = N - 1; i > 0; i--) g[i*N+(i-1)] = 1'b1;
        run_graph(g, "reverse chain");
        g = '0;
        for (int i = 0; i < N; i++) g[i*N+((i+1)%N)] = 1'b1;
        run_graph(g, "ring");
        for (int t = 0; t < 40; t++) run_graph(rnd_graph(5 + (t % 4) * 8), "random");

        // R6: adj toggles while idle, result must hold
        held = clo;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk); adj = rnd_graph(50);
        end
        @(negedge clk);
        chk(clo == held && done, "R6", "hold while idle", clo, held);

        // R7: restart mid-run
        @(negedge clk); adj = '1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        g = rnd_graph(15);
        run_graph(g, "R7 restart");

        cmp_en = 1'b0;
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog run did not end actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end
endmodule